// File: doc/BRIEF.md
# A16 Slot Address Decoder

This block is the slave-side decode for a register-based instrument card on a VME-style backplane. The card answers only in the 16-bit address space and moves 16-bit words. All backplane inputs pass through a two-stage synchroniser to the local clock. When the address strobe falls, the block latches the address and the modifier code. It then decides whether this card is addressed, and holds that decision until the strobe is released.

While the card is selected, the block drives an active-low card select and a one-hot register select taken from the low address bits. It also returns read data from a small register bank. That bank holds three fixed words (identity, device type, status) and one read/write channel word. The channel word drives the relay outputs directly. Bus handshake timing and the analog bus buffers are not part of this block.

Top module: `a16_slot_decoder`

## Requirements
- R1: While rst_ni is low and after reset, card_sel_no is 1, reg_sel_o and rdata_o are 0, and relay_o is 0.
- R2: A cycle can select the card only if the latched modifier am_i equals 6'h29 or 6'h2D. Any other code leaves card_sel_no at 1.
- R3: Selection requires address bits 15 and 14 both at 1.
- R4: Selection requires address bits 13 to 6 to equal the 8-bit la_i value present when the strobe falls.
- R5: Address, modifier and la_i are captured when the synchronised as_ni falls. Later changes to these inputs do not alter the selection or the register index until as_ni returns high. The selection then clears.
- R6: While the card is selected, reg_sel_o has exactly bit addr[5:1] set. Otherwise it is 0.
- R7: When the card is selected, rdata_o returns a fixed word for each of these byte offsets: ID_WORD at 0x00, TYPE_WORD at 0x02, STATUS_WORD at 0x04. At 0x08 it returns the relay state, zero-extended. Every other offset returns 16'hFFFF. When the card is not selected, rdata_o is 0.
- R8: A falling synchronised ds_ni with write_ni low, while the card is selected at offset 0x08, loads wdata_i[NUM_RELAY-1:0] into relay_o.
- R9: Writes at any offset other than 0x08, and writes while the card is not selected, leave relay_o unchanged.
- R10: If ds_ni falls in the same synchronised cycle in which as_ni returns high, no write takes place.
- R11: Every input reaches the logic through two flip-flop stages. Selection appears on the third rising edge after as_ni is sampled low, and a relay write appears on the third rising edge after ds_ni is sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| as_ni | input | 1 | Address strobe, active low |
| ds_ni | input | 1 | Data strobe, active low |
| write_ni | input | 1 | Transfer direction, low for write |
| addr_i | input | 15 | Address bits 15 down to 1 |
| am_i | input | 6 | Address modifier code |
| la_i | input | 8 | Logical address from module switches |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data of selected register |
| card_sel_no | output | 1 | Card addressed, active low |
| reg_sel_o | output | 32 | One-hot register select |
| relay_o | output | NUM_RELAY | Relay drive, from the channel word |

## Verification
Two events can fall in the same cycle: the release of the address strobe, which ends the selection, and a falling data strobe, which asks for a channel write. The bench provokes this by driving as_ni high and ds_ni low on the same clock. A behavioural model built on queues of sampled inputs expects the relays to stay unchanged. That model is compared with every output on every clock, so a write that slips through in this cycle, or a selection that lingers one cycle too long, shows up as a mismatch on relay_o or card_sel_no.

// File: rtl/a16_dec_pkg.sv
package a16_dec_pkg;
  localparam int unsigned ADDR_W = 15;  // bits 15..1
  localparam int unsigned AM_W   = 6;
  localparam int unsigned LA_W   = 8;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned IDX_W  = 5;
  localparam int unsigned NUM_REGS = 1 << IDX_W;

  localparam logic [AM_W-1:0] AM_USER = 6'h29;
  localparam logic [AM_W-1:0] AM_SUP  = 6'h2D;

  typedef enum logic [IDX_W-1:0] {
    IDX_ID   = 5'd0,
    IDX_TYPE = 5'd1,
    IDX_STAT = 5'd2,
    IDX_CHAN = 5'd4
  } reg_idx_e;

  typedef struct packed {
    logic as_n;
    logic ds_n;
    logic wr_n;
  } bus_ctl_t;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [AM_W-1:0]   am;
    logic [LA_W-1:0]   la;
    logic [DATA_W-1:0] wdata;
  } bus_dat_t;

  function automatic logic am_accepted(input logic [AM_W-1:0] am);
    return (am == AM_USER) || (am == AM_SUP);
  endfunction
endpackage

// File: rtl/a16_sync.sv
module a16_sync #(
  parameter int unsigned     W       = 1,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/a16_addr_match.sv
module a16_addr_match
  import a16_dec_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              as_ns_i,
  input  logic [ADDR_W-1:0] addr_s_i,
  input  logic [AM_W-1:0]   am_s_i,
  input  logic [LA_W-1:0]   la_s_i,
  output logic              sel_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic             as_prev_q;
  logic             sel_q;
  logic [IDX_W-1:0] idx_q;
  logic [AM_W-1:0]  am_q;
  logic             as_fall;
  logic             page_ok, la_ok, hit;

  assign as_fall = !as_ns_i && as_prev_q;
  // addr_s_i[k] holds address bit k+1
  assign page_ok = addr_s_i[14] && addr_s_i[13];
  assign la_ok   = (addr_s_i[12:5] == la_s_i);
  assign hit     = am_accepted(am_s_i) && page_ok && la_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      as_prev_q <= 1'b1;
      sel_q     <= 1'b0;
      idx_q     <= '0;
      am_q      <= '0;
    end else begin
      as_prev_q <= as_ns_i;
      if (as_ns_i) begin
        sel_q <= 1'b0;
      end else if (as_fall) begin
        sel_q <= hit;
        idx_q <= addr_s_i[IDX_W-1:0];
        am_q  <= am_s_i;
      end
    end
  end

  assign sel_o = sel_q;
  assign idx_o = idx_q;

  // R5
  sel_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!as_ns_i && !as_prev_q) |=> ($stable(sel_q) && $stable(idx_q)));

  // R2
  am_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_q |-> ((am_q == AM_USER) || (am_q == AM_SUP)));

  // R5
  sel_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    as_ns_i |=> !sel_q);
endmodule

// File: rtl/a16_reg_bank.sv
module a16_reg_bank
  import a16_dec_pkg::*;
#(
  parameter logic [DATA_W-1:0] ID_WORD     = 16'h3F1C,
  parameter logic [DATA_W-1:0] TYPE_WORD   = 16'h7D42,
  parameter logic [DATA_W-1:0] STATUS_WORD = 16'hFFFC,
  parameter int unsigned       NUM_RELAY   = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sel_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic                 as_ns_i,
  input  logic                 ds_ns_i,
  input  logic                 wr_ns_i,
  input  logic [DATA_W-1:0]    wdata_s_i,
  output logic [NUM_REGS-1:0]  reg_sel_o,
  output logic [DATA_W-1:0]    rdata_o,
  output logic [NUM_RELAY-1:0] relay_o
);
  logic                 ds_prev_q;
  logic [NUM_RELAY-1:0] relay_q;
  logic                 ds_fall, chan_wr;
  logic [DATA_W-1:0]    chan_word;
  logic [DATA_W-1:0]    rmux;

  assign ds_fall = !ds_ns_i && ds_prev_q;
  // strobe must still be low: a release in the same cycle cancels the write
  assign chan_wr = sel_i && !as_ns_i && ds_fall && !wr_ns_i &&
                   (idx_i == IDX_CHAN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ds_prev_q <= 1'b1;
      relay_q   <= '0;
    end else begin
      ds_prev_q <= ds_ns_i;
      if (chan_wr) relay_q <= wdata_s_i[NUM_RELAY-1:0];
    end
  end

  always_comb begin
    chan_word = '0;
    chan_word[NUM_RELAY-1:0] = relay_q;
  end

  always_comb begin
    unique case (idx_i)
      IDX_ID:   rmux = ID_WORD;
      IDX_TYPE: rmux = TYPE_WORD;
      IDX_STAT: rmux = STATUS_WORD;
      IDX_CHAN: rmux = chan_word;
      default:  rmux = '1;
    endcase
  end

  assign rdata_o = sel_i ? rmux : '0;
  assign relay_o = relay_q;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_rsel
    assign reg_sel_o[g] = sel_i && (idx_i == IDX_W'(g));
  end

  // R6
  rsel_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i |-> ($countones(reg_sel_o) == 1));

  // R6
  rsel_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |-> (reg_sel_o == '0));

  // R9
  relay_unsel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |=> $stable(relay_q));

  // R10
  relay_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    as_ns_i |=> $stable(relay_q));

  // R9
  relay_offset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_i != IDX_CHAN) |=> $stable(relay_q));
endmodule

// File: rtl/a16_slot_decoder.sv
module a16_slot_decoder
  import a16_dec_pkg::*;
#(
  parameter logic [15:0] ID_WORD     = 16'h3F1C,
  parameter logic [15:0] TYPE_WORD   = 16'h7D42,
  parameter logic [15:0] STATUS_WORD = 16'hFFFC,
  parameter int unsigned NUM_RELAY   = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 as_ni,
  input  logic                 ds_ni,
  input  logic                 write_ni,
  input  logic [14:0]          addr_i,
  input  logic [5:0]           am_i,
  input  logic [7:0]           la_i,
  input  logic [15:0]          wdata_i,
  output logic [15:0]          rdata_o,
  output logic                 card_sel_no,
  output logic [31:0]          reg_sel_o,
  output logic [NUM_RELAY-1:0] relay_o
);
  localparam int unsigned CTL_W = $bits(bus_ctl_t);
  localparam int unsigned DAT_W = $bits(bus_dat_t);

  bus_ctl_t         ctl_raw, ctl_s;
  bus_dat_t         dat_raw, dat_s;
  logic             sel;
  logic [IDX_W-1:0] idx;

  assign ctl_raw = '{as_n: as_ni, ds_n: ds_ni, wr_n: write_ni};
  assign dat_raw = '{addr: addr_i, am: am_i, la: la_i, wdata: wdata_i};

  a16_sync #(.W(CTL_W), .RST_VAL({CTL_W{1'b1}})) u_sync_ctl (
    .clk_i, .rst_ni, .d_i(ctl_raw), .q_o(ctl_s)
  );

  a16_sync #(.W(DAT_W), .RST_VAL({DAT_W{1'b0}})) u_sync_dat (
    .clk_i, .rst_ni, .d_i(dat_raw), .q_o(dat_s)
  );

  a16_addr_match u_match (
    .clk_i, .rst_ni,
    .as_ns_i (ctl_s.as_n),
    .addr_s_i(dat_s.addr),
    .am_s_i  (dat_s.am),
    .la_s_i  (dat_s.la),
    .sel_o   (sel),
    .idx_o   (idx)
  );

  a16_reg_bank #(
    .ID_WORD(ID_WORD), .TYPE_WORD(TYPE_WORD),
    .STATUS_WORD(STATUS_WORD), .NUM_RELAY(NUM_RELAY)
  ) u_bank (
    .clk_i, .rst_ni,
    .sel_i    (sel),
    .idx_i    (idx),
    .as_ns_i  (ctl_s.as_n),
    .ds_ns_i  (ctl_s.ds_n),
    .wr_ns_i  (ctl_s.wr_n),
    .wdata_s_i(dat_s.wdata),
    .reg_sel_o(reg_sel_o),
    .rdata_o  (rdata_o),
    .relay_o  (relay_o)
  );

  assign card_sel_no = !sel;

  // R1
  reset_idle_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (card_sel_no && relay_o == '0));
endmodule

// File: tb/a16_slot_decoder_test.sv
`timescale 1ns/1ps
module a16_slot_decoder_test;
  localparam logic [15:0] EXP_ID   = 16'h3F1C;
  localparam logic [15:0] EXP_TYPE = 16'h7D42;
  localparam logic [15:0] EXP_STAT = 16'hFFFC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic as_n = 1'b1, ds_n = 1'b1, wr_n = 1'b1;
  logic [15:0] addr = '0;
  logic [5:0]  am = '0;
  logic [7:0]  la = '0;
  logic [15:0] wd = '0;
  logic [15:0] rdata;
  logic        card_sel_n;
  logic [31:0] reg_sel;
  logic [15:0] relay;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  a16_slot_decoder uut (
    .clk_i(clk), .rst_ni(rst_n), .as_ni(as_n), .ds_ni(ds_n),
    .write_ni(wr_n), .addr_i(addr[15:1]), .am_i(am), .la_i(la),
    .wdata_i(wd), .rdata_o(rdata), .card_sel_no(card_sel_n),
    .reg_sel_o(reg_sel), .relay_o(relay)
  );

  typedef struct {
    bit as_n, ds_n, wr_n;
    bit [15:0] addr;
    bit [5:0]  am;
    bit [7:0]  la;
    bit [15:0] wd;
  } smp_t;

  smp_t hist[$];
  bit        m_sel;
  bit [4:0]  m_idx;
  bit [15:0] m_chan;

  function automatic smp_t idle_smp();
    smp_t s;
    s.as_n = 1; s.ds_n = 1; s.wr_n = 1;
    s.addr = 0; s.am = 0; s.la = 0; s.wd = 0;
    return s;
  endfunction

  function automatic bit hit_of(smp_t s);
    return (s.am == 6'h29 || s.am == 6'h2D) && s.addr[15:14] == 2'b11 &&
           s.addr[13:6] == s.la;
  endfunction

  // R11: a raw sample reaches the logic two edges after it is taken
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = {idle_smp(), idle_smp(), idle_smp(), idle_smp()};
      m_sel = 0; m_idx = 0; m_chan = 0;
    end else begin
      smp_t cur, prv, raw;
      raw.as_n = as_n; raw.ds_n = ds_n; raw.wr_n = wr_n;
      raw.addr = addr; raw.am = am; raw.la = la; raw.wd = wd;
      hist.push_front(raw);
      void'(hist.pop_back());
      cur = hist[2];
      prv = hist[3];
      if (m_sel && !cur.as_n && !cur.ds_n && prv.ds_n && !cur.wr_n && m_idx == 5'd4)
        m_chan = cur.wd;
      if (cur.as_n) m_sel = 0;
      else if (prv.as_n) begin
        m_sel = hit_of(cur);
        m_idx = cur.addr[5:1];
      end
    end
  end

  function automatic bit [15:0] exp_rdata();
    if (!m_sel) return 16'h0;
    case (m_idx)
      5'd0: return EXP_ID;
      5'd1: return EXP_TYPE;
      5'd2: return EXP_STAT;
      5'd4: return m_chan;
      default: return 16'hFFFF;
    endcase
  endfunction

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    chk("card_sel_no", {31'b0, card_sel_n}, {31'b0, !m_sel});
    chk("reg_sel_o", reg_sel, m_sel ? (32'h1 << m_idx) : 32'h0);
    chk("rdata_o", {16'b0, rdata}, {16'b0, exp_rdata()});
    chk("relay_o", {16'b0, relay}, {16'b0, m_chan});
  endtask

  task automatic wait_n(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic access(bit [15:0] a, bit [5:0] code, bit [7:0] sw,
                        bit do_wr, bit [15:0] data);
    addr = a; am = code; la = sw; wr_n = !do_wr; wd = data;
    as_n = 0;
    wait_n(5);
    ds_n = 0;
    wait_n(4);
    ds_n = 1; as_n = 1; wr_n = 1;
    wait_n(5);
  endtask

  function automatic bit [15:0] mk(bit [7:0] sw, bit [5:0] off);
    return {2'b11, sw, off};
  endfunction

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cur_req = "R1";
    wait_n(3);
    rst_n = 1;
    wait_n(3);

    cur_req = "R7";
    access(mk(8'h5A, 6'h00), 6'h29, 8'h5A, 0, 0);
    access(mk(8'h5A, 6'h02), 6'h29, 8'h5A, 0, 0);
    access(mk(8'h5A, 6'h04), 6'h2D, 8'h5A, 0, 0);
    access(mk(8'h5A, 6'h06), 6'h29, 8'h5A, 0, 0);
    access(mk(8'h5A, 6'h3E), 6'h29, 8'h5A, 0, 0);

    cur_req = "R6";
    access(mk(8'hC3, 6'h1A), 6'h2D, 8'hC3, 0, 0);

    cur_req = "R2";
    access(mk(8'h5A, 6'h00), 6'h39, 8'h5A, 0, 0);
    access(mk(8'h5A, 6'h08), 6'h3D, 8'h5A, 1, 16'h1234);

    cur_req = "R3";
    access({2'b10, 8'h5A, 6'h00}, 6'h29, 8'h5A, 0, 0);
    access({2'b01, 8'h5A, 6'h00}, 6'h29, 8'h5A, 0, 0);

    cur_req = "R4";
    access(mk(8'h5B, 6'h00), 6'h29, 8'h5A, 0, 0);
    access(mk(8'h00, 6'h08), 6'h29, 8'hFF, 1, 16'h4321);

    cur_req = "R8";
    access(mk(8'h5A, 6'h08), 6'h29, 8'h5A, 1, 16'hA5C3);
    access(mk(8'h5A, 6'h08), 6'h29, 8'h5A, 0, 0);
    access(mk(8'h81, 6'h08), 6'h2D, 8'h81, 1, 16'h0F0F);

    cur_req = "R9";
    access(mk(8'h81, 6'h00), 6'h2D, 8'h81, 1, 16'hFFFF);
    access(mk(8'h81, 6'h04), 6'h2D, 8'h81, 1, 16'h5555);
    access(mk(8'h82, 6'h08), 6'h2D, 8'h81, 1, 16'h9999);
    access(mk(8'h81, 6'h08), 6'h2D, 8'h81, 0, 0);

    cur_req = "R5";
    addr = mk(8'h44, 6'h08); am = 6'h29; la = 8'h44; wr_n = 1;
    as_n = 0;
    wait_n(6);
    addr = mk(8'h10, 6'h00); am = 6'h3F; la = 8'h99;
    wait_n(5);
    as_n = 1;
    wait_n(5);

    cur_req = "R10";
    addr = mk(8'h44, 6'h08); am = 6'h29; la = 8'h44; wr_n = 0; wd = 16'hBEEF;
    as_n = 0;
    wait_n(6);
    ds_n = 0; as_n = 1;
    wait_n(3);
    ds_n = 1; wr_n = 1;
    wait_n(4);
    access(mk(8'h44, 6'h08), 6'h29, 8'h44, 0, 0);

    cur_req = "R11";
    access(mk(8'h44, 6'h08), 6'h29, 8'h44, 1, 16'h00F1);

    cur_req = "R1";
    rst_n = 0;
    wait_n(2);
    rst_n = 1;
    wait_n(3);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule